// File: doc/BRIEF.md
# Dual cascadable compare timer

The block is a memory-mapped timer with two counter channels, low and high, each `CNT_W` bits wide (32 by default). Software reaches it over a simple register bus with one-cycle writes and combinational reads. Each channel has a configuration word, a counter, a comparator, a start command and a reset command. A channel counts in one of three ways: once per system clock, once every (1 + P) system clocks through a prescaler, or once per pulse of a slow reference tick. The reference tick is already synchronised and arrives as a single-cycle pulse.

On a counting tick where the counter equals its compare value, the channel raises a match. A match can return the counter to zero (cycle mode), or the counter can keep incrementing (continue mode). A match can also stop the channel (one-shot). If the channel's interrupt enable is set, the match drives a one-clock interrupt pulse.

A cascade bit joins the two channels into one 2·`CNT_W`-bit counter. This counter is compared against {compare high, compare low} and is governed by the low channel's configuration.

Top module: `cascade_timer`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: Registers are selected by `addr_i[5:2]` (byte offsets):
  - 0x00 low config, 0x04 high config, 0x08/0x0C low/high counter, 0x10/0x14 low/high compare, 0x18/0x1C low/high start, 0x20/0x24 low/high reset.
  - Config bits are: 0 enable, 1 reset, 2 interrupt enable, 3 event mask (stored only), 4 mode (1 = cycle), 5 one-shot, 6 prescaler enable, 7 source (1 = reference tick).
  - The low config also holds the prescale value P in bits 15:8 and cascade in bit 31.
  - Undefined config bits read zero.
  - Counter and compare writes keep the low `CNT_W` bits.
- R3: Writing a start register with bit 0 = 1 sets that channel's enable bit. Writing a reset register with bit 0 = 1 sets that channel's reset bit. A command write with bit 0 = 0 changes nothing. Start and reset registers read zero.
- R4: An enabled channel on the system clock with the prescaler off adds one per clock. A disabled channel holds its count.
- R5: With the prescaler on, a channel advances once every P + 1 clocks, counting from its start. P is taken from the low config for both channels.
- R6: With source = 1, a channel advances once per `ref_tick_i` pulse, whatever the prescaler setting.
- R7: In cycle mode with compare value C, a tick at count C loads zero, so the count after k ticks is k mod (C + 1).
- R8: In continue mode the counter keeps incrementing through the match.
- R9: With one-shot set, a match clears the enable bit. Counting stops at C + 1 in continue mode and at 0 in cycle mode.
- R10: The interrupt output goes high for one clock, in the clock after a match tick, and only if the interrupt enable bit is set.
- R11: A set reset bit clears the counter and the prescaler at the next edge, then clears itself. Counting resumes on the following tick.
- R12: A bus write to a counter takes effect at the next edge, ahead of any tick, match or reset in the same cycle.
- R13: With cascade set, the two counters form {high, low}, compared against {compare high, compare low}. The high counter advances only when the low counter wraps from all-ones. The low config's mode, one-shot, prescaler and interrupt enable apply to the joined counter, and `irq_hi_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | ADDR_W | Byte address, word index in bits 5:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ref_tick_i | input | 1 | Single-cycle reference clock tick |
| irq_lo_o | output | 1 | Low channel (or joined counter) match interrupt |
| irq_hi_o | output | 1 | High channel match interrupt |

## Verification
The collision of interest is a software write to a counter landing on the same edge as a counting tick, which can also be a cycle-mode match. It is provoked by running the low channel in cycle mode with no prescaler, so that every clock is a tick. The count is read until it sits at the compare value, and the counter is then written. The result is judged correct when the written value survives the wrap that the match would otherwise have forced, and counting continues upward from it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;

  // word indices, channel added to base
  localparam logic [3:0] IDX_CFG   = 4'd0;
  localparam logic [3:0] IDX_CNT   = 4'd2;
  localparam logic [3:0] IDX_CMP   = 4'd4;
  localparam logic [3:0] IDX_START = 4'd6;
  localparam logic [3:0] IDX_RESET = 4'd8;

  // config bit positions
  localparam int B_EN    = 0;
  localparam int B_RST   = 1;
  localparam int B_IRQ   = 2;
  localparam int B_IEM   = 3;
  localparam int B_MODE  = 4;
  localparam int B_ONE   = 5;
  localparam int B_PEN   = 6;
  localparam int B_SRC   = 7;
  localparam int B_PVAL  = 8;
  localparam int B_CASC  = 31;
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int PVAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              ref_sel_i,
  input  logic              pre_en_i,
  input  logic [PVAL_W-1:0] pval_i,
  input  logic              ref_tick_i,
  output logic              tick_o
);
  logic [PVAL_W-1:0] pcnt_q;
  logic              pre_hit;

  assign pre_hit = (pcnt_q == pval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!en_i || clr_i)    pcnt_q <= '0;
    else if (!ref_sel_i && pre_en_i)
      pcnt_q <= pre_hit ? '0 : pcnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i &&
                  (ref_sel_i ? ref_tick_i : (!pre_en_i || pre_hit));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             zero_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (ld_i)   cnt_o <= ld_val_i;
    else if (zero_i) cnt_o <= '0;
    else if (adv_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PVAL_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ref_tick_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic [3:0] widx;
  logic       wr;
  assign widx = addr_i[5:2];
  assign wr   = req_i && we_i;

  logic [NCH-1:0] en_q, rstc_q, irqen_q, iem_q, mode_q, one_q, pen_q, src_q;
  logic [PVAL_W-1:0] pval_q;
  logic              casc_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_q, cmp_q;
  logic [NCH-1:0] wr_cfg, wr_cnt, wr_cmp, wr_start, wr_reset;
  logic [NCH-1:0] tick, hit, wrap, adv, zero, irq_q;

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pval_q <= '0;
      casc_q <= 1'b0;
    end else if (wr_cfg[0]) begin
      pval_q <= wdata_i[B_PVAL +: PVAL_W];
      casc_q <= wdata_i[B_CASC];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_cfg[i]   = wr && (widx == IDX_CFG   + 4'(i));
    assign wr_cnt[i]   = wr && (widx == IDX_CNT   + 4'(i));
    assign wr_cmp[i]   = wr && (widx == IDX_CMP   + 4'(i));
    assign wr_start[i] = wr && (widx == IDX_START + 4'(i));
    assign wr_reset[i] = wr && (widx == IDX_RESET + 4'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i] <= 1'b0; rstc_q[i] <= 1'b0; irqen_q[i] <= 1'b0; iem_q[i] <= 1'b0;
        mode_q[i] <= 1'b0; one_q[i] <= 1'b0; pen_q[i] <= 1'b0; src_q[i] <= 1'b0;
      end else if (wr_cfg[i]) begin
        en_q[i]    <= wdata_i[B_EN];
        rstc_q[i]  <= wdata_i[B_RST];
        irqen_q[i] <= wdata_i[B_IRQ];
        iem_q[i]   <= wdata_i[B_IEM];
        mode_q[i]  <= wdata_i[B_MODE];
        one_q[i]   <= wdata_i[B_ONE];
        pen_q[i]   <= wdata_i[B_PEN];
        src_q[i]   <= wdata_i[B_SRC];
      end else begin
        if (wr_start[i] && wdata_i[0])  en_q[i] <= 1'b1;
        else if (hit[i] && one_q[i])    en_q[i] <= 1'b0;
        if (wr_reset[i] && wdata_i[0])  rstc_q[i] <= 1'b1;
        else if (rstc_q[i])             rstc_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[i] <= '0;
      else if (wr_cmp[i]) cmp_q[i] <= wdata_i[CNT_W-1:0];
    end

    timer_tick_gen #(.PVAL_W(PVAL_W)) u_tick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_q[i] && !((i == 1) && casc_q)),
      .clr_i      (rstc_q[i]),
      .ref_sel_i  (src_q[i]),
      .pre_en_i   (pen_q[i]),
      .pval_i     (pval_q),
      .ref_tick_i (ref_tick_i),
      .tick_o     (tick[i])
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (wr_cnt[i]),
      .ld_val_i (wdata_i[CNT_W-1:0]),
      .zero_i   (zero[i]),
      .adv_i    (adv[i]),
      .cnt_o    (cnt_q[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[i] <= 1'b0;
      else         irq_q[i] <= hit[i] && irqen_q[i];
    end
  end

  // match, wrap and carry; in cascade the high half follows the low half
  logic eq_lo, eq_hi, lo_carry;
  always_comb begin
    eq_lo    = (cnt_q[0] == cmp_q[0]);
    eq_hi    = (cnt_q[1] == cmp_q[1]);
    lo_carry = tick[0] && (&cnt_q[0]) && !wr_cnt[0] && !rstc_q[0];
    hit[0]   = tick[0] && eq_lo && (!casc_q || eq_hi);
    hit[1]   = !casc_q && tick[1] && eq_hi;
    wrap[0]  = hit[0] && mode_q[0];
    wrap[1]  = casc_q ? wrap[0] : (hit[1] && mode_q[1]);
    adv[0]   = tick[0];
    adv[1]   = casc_q ? lo_carry : tick[1];
    zero     = rstc_q | wrap;
  end

  assign irq_lo_o = irq_q[0];
  assign irq_hi_o = irq_q[1];

  always_comb begin
    rdata_o = '0;
    case (widx)
      IDX_CFG:        rdata_o = {casc_q, 15'd0, pval_q, src_q[0], pen_q[0], one_q[0],
                                 mode_q[0], iem_q[0], irqen_q[0], rstc_q[0], en_q[0]};
      IDX_CFG + 4'd1: rdata_o = {24'd0, src_q[1], pen_q[1], one_q[1],
                                 mode_q[1], iem_q[1], irqen_q[1], rstc_q[1], en_q[1]};
      IDX_CNT:        rdata_o = DATA_W'(cnt_q[0]);
      IDX_CNT + 4'd1: rdata_o = DATA_W'(cnt_q[1]);
      IDX_CMP:        rdata_o = DATA_W'(cmp_q[0]);
      IDX_CMP + 4'd1: rdata_o = DATA_W'(cmp_q[1]);
      default:        rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic                  irq_lo_o,
  input logic                  irq_hi_o,
  input logic [1:0]            en_q,
  input logic [1:0]            rstc_q,
  input logic [1:0]            irqen_q,
  input logic                  casc_q,
  input logic [1:0][CNT_W-1:0] cnt_q
);
  logic [3:0] widx;
  logic       wr;
  assign widx = addr_i[5:2];
  assign wr   = req_i && we_i;

  p_cmd_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx >= 4'd6) |-> (rdata_o == 32'd0));

  p_start_sets_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == 4'd6 && wdata_i[0]) |=> en_q[0]);

  p_irq_lo_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> $past(irqen_q[0]));

  p_irq_hi_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> $past(irqen_q[1]));

  p_reset_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstc_q[0] && !(wr && widx == 4'd2)) |=> (cnt_q[0] == '0));

  p_reset_selfclear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstc_q[0] && !(wr && (widx == 4'd0 || widx == 4'd8))) |=> !rstc_q[0]);

  p_cnt_write_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == 4'd2) |=> (cnt_q[0] == $past(wdata_i[CNT_W-1:0])));

  p_casc_hi_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_q |=> !irq_hi_o);
endmodule

bind cascade_timer timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_lo_o (irq_lo_o),
  .irq_hi_o (irq_hi_o),
  .en_q     (en_q),
  .rstc_q   (rstc_q),
  .irqen_q  (irqen_q),
  .casc_q   (casc_q),
  .cnt_q    (cnt_q)
);

// File: tb/sim_cascade_timer.sv
module sim_cascade_timer;
  localparam int CW = 8;
  localparam logic [3:0] CFG_LO = 0, CFG_HI = 1, CNT_LO = 2, CNT_HI = 3, CMP_LO = 4,
                         CMP_HI = 5, START_LO = 6, START_HI = 7, RST_LO = 8, RST_HI = 9;
  localparam logic [31:0] F_EN = 32'h1, F_RST = 32'h2, F_IRQ = 32'h4, F_MODE = 32'h10,
                          F_ONE = 32'h20, F_PEN = 32'h40, F_SRC = 32'h80, F_CASC = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b0;
  logic        irq_lo, irq_hi;

  int checks = 0, fails = 0, irq_lo_n = 0, irq_hi_n = 0;
  bit done = 1'b0;
  logic [31:0] d, d2;

  always #10 clk = ~clk;

  cascade_timer #(.CNT_W(CW), .PVAL_W(8), .ADDR_W(6)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ref_tick_i(ref_tick),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] v);
    addr = {idx, 2'b00}; wdata = v; req = 1'b1; we = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    addr = {idx, 2'b00}; req = 1'b1; we = 1'b0;
    #1 v = rdata;
    req = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq_lo_n += int'(irq_lo);
      irq_hi_n += int'(irq_hi);
    end
  endtask

  task automatic run_ref(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = (i % 3 == 0);
      @(negedge clk);
    end
    ref_tick = 1'b0;
  endtask

  task automatic setup_lo(input logic [31:0] cfg, input logic [31:0] cmp);
    wr(CFG_LO, cfg); wr(CMP_LO, cmp); wr(CNT_LO, 0);
    irq_lo_n = 0; irq_hi_n = 0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 10; r++) begin
      rd(4'(r), d);
      chk($sformatf("R1 reg %0d", r), d, 0);
    end
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);

    // R2 readback masks and truncation
    wr(CFG_LO, 32'hFFFF_FFFC); rd(CFG_LO, d); chk("R2 cfg_lo mask", d, 32'h8000_FFFC);
    wr(CFG_HI, 32'hFFFF_FFFC); rd(CFG_HI, d); chk("R2 cfg_hi mask", d, 32'h0000_00FC);
    wr(CNT_LO, 32'h1234);      rd(CNT_LO, d); chk("R2 cnt width", d, 32'h34);
    wr(CMP_HI, 32'hABCD);      rd(CMP_HI, d); chk("R2 cmp width", d, 32'hCD);
    wr(CFG_LO, 0); wr(CFG_HI, 0); wr(CMP_HI, 0);

    // R3 command registers
    wr(START_LO, 32'hFFFF_FFFE); rd(CFG_LO, d); chk("R3 start bit0=0 ignored", d, 0);
    wr(RST_HI, 32'hFFFF_FFFE);   rd(CFG_HI, d); chk("R3 reset bit0=0 ignored", d, 0);
    rd(START_HI, d); chk("R3 start reads zero", d, 0);
    rd(RST_LO, d);   chk("R3 reset reads zero", d, 0);
    wr(START_LO, 1); rd(CFG_LO, d); chk("R3 start sets enable", d, F_EN);
    wr(CFG_LO, 0);

    // R4 plain system clock count and hold when disabled
    setup_lo(0, 32'hFF); wr(START_LO, 1); run(37);
    rd(CNT_LO, d); chk("R4 sysclk count", d, 37);
    wr(CFG_LO, 0); rd(CNT_LO, d); run(10); rd(CNT_LO, d2);
    chk("R4 disabled holds", d2, d);

    // R5 prescaler sweep, both channels, shared P
    for (int p = 0; p < 8; p++) begin
      wr(CFG_LO, F_PEN | (32'(p) << 8)); wr(CFG_HI, F_PEN);
      wr(CNT_LO, 0); wr(CNT_HI, 0); wr(CMP_LO, 32'hFF); wr(CMP_HI, 32'hFF);
      wr(START_LO, 1); wr(START_HI, 1); run(50);
      rd(CNT_LO, d); chk($sformatf("R5 lo P=%0d", p), d, 32'(51 / (p + 1)));
      rd(CNT_HI, d); chk($sformatf("R5 hi P=%0d", p), d, 32'(50 / (p + 1)));
      wr(CFG_LO, 0); wr(CFG_HI, 0);
    end

    // R6 reference tick source, prescaler set but ignored
    setup_lo(F_SRC | F_PEN | (32'd3 << 8), 32'hFF); wr(START_LO, 1); run_ref(30);
    rd(CNT_LO, d); chk("R6 ref ticks", d, 10);
    run(8); rd(CNT_LO, d); chk("R6 no ref no count", d, 10);
    wr(CFG_LO, 0);

    // R7 cycle mode sweep with R10 pulse counting
    for (int p = 0; p < 3; p += 2) begin
      for (int c = 0; c < 7; c++) begin
        setup_lo(F_MODE | F_IRQ | F_PEN | (32'(p) << 8), 32'(c));
        wr(START_LO, 1); run(60);
        rd(CNT_LO, d);
        chk($sformatf("R7 cycle C=%0d P=%0d", c, p), d, 32'((60 / (p + 1)) % (c + 1)));
        chk($sformatf("R10 pulses C=%0d P=%0d", c, p), 32'(irq_lo_n),
            32'((60 / (p + 1)) / (c + 1)));
        wr(CFG_LO, 0);
      end
    end

    // R10 interrupt enable off
    setup_lo(F_MODE, 2); wr(START_LO, 1); run(30);
    rd(CNT_LO, d); chk("R10 count without irq", d, 0);
    chk("R10 no pulse when disabled", 32'(irq_lo_n), 0);
    wr(CFG_LO, 0);

    // R8 continue mode
    setup_lo(F_IRQ, 9); wr(START_LO, 1); run(40);
    rd(CNT_LO, d); chk("R8 continue count", d, 40);
    chk("R8 one match", 32'(irq_lo_n), 1);
    wr(CFG_LO, 0);

    // R9 one-shot, continue and cycle
    setup_lo(F_IRQ | F_ONE, 5); wr(START_LO, 1); run(20);
    rd(CNT_LO, d); chk("R9 one-shot stop count", d, 6);
    rd(CFG_LO, d); chk("R9 enable cleared", d, F_IRQ | F_ONE);
    chk("R9 one pulse", 32'(irq_lo_n), 1);
    setup_lo(F_IRQ | F_ONE | F_MODE, 5); wr(START_LO, 1); run(20);
    rd(CNT_LO, d); chk("R9 one-shot cycle count", d, 0);
    rd(CFG_LO, d); chk("R9 cycle enable cleared", d, F_IRQ | F_ONE | F_MODE);
    wr(CFG_LO, 0);

    // R11 reset command
    setup_lo(0, 32'hFF); wr(START_LO, 1); run(20);
    rd(CNT_LO, d); chk("R11 before reset", d, 20);
    wr(RST_LO, 1);
    rd(CNT_LO, d); chk("R11 count at reset edge", d, 21);
    rd(CFG_LO, d); chk("R11 reset bit visible", d, F_EN | F_RST);
    run(5);
    rd(CNT_LO, d); chk("R11 resumed from zero", d, 4);
    rd(CFG_LO, d); chk("R11 reset bit self-cleared", d, F_EN);

    // R12 counter write beats counting
    wr(CNT_LO, 32'h40); rd(CNT_LO, d); chk("R12 load over tick", d, 32'h40);
    run(5); rd(CNT_LO, d); chk("R12 count after load", d, 32'h45);
    wr(CFG_LO, 0);
    setup_lo(F_MODE, 3); wr(START_LO, 1); run(7);
    rd(CNT_LO, d); chk("R12 at compare", d, 3);
    wr(CNT_LO, 32'h20); rd(CNT_LO, d); chk("R12 load over wrap", d, 32'h20);
    run(2); rd(CNT_LO, d); chk("R12 counts from load", d, 32'h22);
    wr(CFG_LO, 0);

    // R13 cascade, continue then cycle
    wr(CFG_HI, 0); wr(CNT_HI, 0); wr(CMP_HI, 32'hFF);
    setup_lo(F_CASC, 32'hFF); wr(CNT_LO, 32'hF0); wr(START_LO, 1); run(40);
    rd(CNT_LO, d); rd(CNT_HI, d2);
    chk("R13 casc lo", d, 32'h18); chk("R13 casc hi carry", d2, 32'h01);
    wr(CFG_LO, 0);
    wr(CFG_HI, F_IRQ); wr(CNT_HI, 0); wr(CMP_HI, 1);
    setup_lo(F_CASC | F_MODE | F_IRQ, 5); wr(START_LO, 1); run(300);
    rd(CNT_LO, d); rd(CNT_HI, d2);
    chk("R13 casc cycle lo", d, 38); chk("R13 casc cycle hi", d2, 0);
    chk("R13 casc lo pulse", 32'(irq_lo_n), 1);
    chk("R13 casc hi silent", 32'(irq_hi_n), 0);
    wr(CFG_LO, 0); wr(CFG_HI, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule